// File: doc/BRIEF.md
# Interrupt Controller Command and Register Interface

This block is the software-facing front end of an eight-line interrupt controller. A processor writes bytes to two address slots and reads bytes back. Writes at slot 0 fall into three classes, told apart by bits 4 and 3 of the byte:

- start of initialization;
- a mode command;
- a priority operation.

Writes at slot 1 either load the line mask or feed the remaining words of a multi-step initialization. Whether the last word of that sequence is needed depends on a flag taken from the first word.

The block holds the controller's configuration and passes it to a separate priority resolver:

- vector base;
- auto end-of-interrupt;
- rotate on auto end-of-interrupt;
- fully nested cascade handling;
- special mask.

Each priority operation becomes a one-cycle pulse, with a line number where the operation names one. The resolver sends back its request bits, its in-service bits and its current winning line. From these the block builds the read data.

A poll read returns the winning line, or 7 when no line is pending. It also sends a pulse to the resolver that clears that line's request and in-service bits. Two settings in the first initialization word cannot be honoured: single-controller operation (bit 1) and level-triggered inputs (bit 3). A request for either is recorded in a sticky flag.

Top module: `irq_prog_if`

## Requirements
- R1: After reset the mask, vector base, all mode bits, both sticky flags and all pulses are zero. A read at slot 0 returns the request bits.
- R2: A slot-0 write with bit 4 set starts initialization. One cycle later `init_p` pulses for one cycle. Mask, vector base, auto-EOI, rotate-on-auto-EOI, fully nested, special mask, read-select and poll are all cleared. Bit 0 records whether a fourth word follows.
- R3: Bit 1 of an initialization word sets `single_seen` and bit 3 sets `level_seen`. Both flags stay set until reset; a later initialization does not clear them.
- R4: After initialization, the first slot-1 write stores bits 7:3 as `vec_base`. The second slot-1 write completes the sequence when no fourth word is expected. Neither write changes the mask. Once the sequence is done, slot-1 writes load the mask again.
- R5: When a fourth word is expected, the third slot-1 write sets `full_nest` from bit 4 and `auto_eoi` from bit 1.
- R6: A slot-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 turns poll on. Bit 1 enables bit 0 to choose the in-service bits (1) or the request bits (0) for slot-0 reads. Bit 6 enables bit 5 to set or clear `spec_mask`.
- R7: Any other slot-0 write decodes bits 7:5 as an operation. Its pulse appears for one cycle, one cycle after the write, and at most one operation pulse is ever high. The codes are: 1 `eoi_p`, 5 `rot_eoi_p`, 3 `spec_eoi_p`, 6 `set_prio_p`, 7 `spec_rot_p`. Bits 2:0 of the byte appear on `cmd_line`.
- R8: Operation codes 0 and 4 load `rot_auto_eoi` from bit 7. Code 2 changes no state and produces no pulse.
- R9: When poll is off, `rdata` is combinational. Slot 1 returns the mask. Slot 0 returns the in-service or request bits according to the read-select.
- R10: A read while poll is on returns the pending line number in bits 2:0, or 7 when nothing is pending. Poll is then off. When a line was pending, `poll_clr_p` pulses on the next cycle with that line on `poll_clr_line`.
- R11: A slot-1 write with no initialization in progress loads the mask one cycle later and pulses `mask_wr_p`. The mask changes at no other time except initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Slot select |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational) |
| req_bits | input | 8 | Request bits from the resolver |
| svc_bits | input | 8 | In-service bits from the resolver |
| pend_vld | input | 1 | Resolver has a winning line |
| pend_line | input | 3 | Winning line number |
| imr | output | 8 | Line mask |
| vec_base | output | 5 | Vector base, upper five bits |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on auto end-of-interrupt |
| full_nest | output | 1 | Fully nested cascade mode |
| spec_mask | output | 1 | Special mask mode |
| init_p | output | 1 | Initialization pulse (drop interrupt, clear request and in-service bits) |
| mask_wr_p | output | 1 | Mask written pulse |
| eoi_p | output | 1 | Non-specific EOI pulse |
| rot_eoi_p | output | 1 | Rotating EOI pulse |
| spec_eoi_p | output | 1 | Specific EOI pulse |
| set_prio_p | output | 1 | Set lowest priority pulse |
| spec_rot_p | output | 1 | Specific EOI with rotate pulse |
| cmd_line | output | 3 | Line named by the last operation |
| poll_clr_p | output | 1 | Clear polled line pulse |
| poll_clr_line | output | 3 | Line to clear after a poll |
| single_seen | output | 1 | Sticky: single mode was requested |
| level_seen | output | 1 | Sticky: level trigger was requested |

## Verification
A wrong initialization step shows up on the next slot-1 write in one of two ways: a byte meant for the vector base lands in the mask with a `mask_wr_p` pulse, or a mask byte is swallowed. A stuck read-select or poll bit appears on `rdata` on the very next read, because the read path is combinational. The bench therefore follows every initialization word and every mode change with a write or read whose result depends on that state. It checks pulses in the exact cycle after each write and again one cycle later, so a pulse that is late, early or stretched is caught.

// File: rtl/irq_prog_if.sv
module irq_prog_if #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] svc_bits,
  input  logic          pend_vld,
  input  logic [2:0]    pend_line,
  output logic [DW-1:0] imr,
  output logic [4:0]    vec_base,
  output logic          auto_eoi,
  output logic          rot_auto_eoi,
  output logic          full_nest,
  output logic          spec_mask,
  output logic          init_p,
  output logic          mask_wr_p,
  output logic          eoi_p,
  output logic          rot_eoi_p,
  output logic          spec_eoi_p,
  output logic          set_prio_p,
  output logic          spec_rot_p,
  output logic [2:0]    cmd_line,
  output logic          poll_clr_p,
  output logic [2:0]    poll_clr_line,
  output logic          single_seen,
  output logic          level_seen
);
  localparam int LW = 3;
  localparam logic [DW-1:0] EMPTY_POLL = DW'(7);

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} step_t;

  step_t step;
  logic  want4, rd_isr, poll_on;

  logic wr0, wr1, wr_init, wr_mode, wr_op;
  assign wr0     = wr_en & ~addr;
  assign wr1     = wr_en & addr;
  assign wr_init = wr0 & wdata[4];
  assign wr_mode = wr0 & ~wdata[4] & wdata[3];
  assign wr_op   = wr0 & ~wdata[4] & ~wdata[3];

  assign rdata = poll_on ? (pend_vld ? DW'(pend_line) : EMPTY_POLL)
               : addr    ? imr
               : rd_isr  ? svc_bits : req_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_RUN;
      want4 <= 1'b0;
      rd_isr <= 1'b0;
      poll_on <= 1'b0;
      imr <= '0;
      vec_base <= '0;
      auto_eoi <= 1'b0;
      rot_auto_eoi <= 1'b0;
      full_nest <= 1'b0;
      spec_mask <= 1'b0;
      init_p <= 1'b0;
      mask_wr_p <= 1'b0;
      eoi_p <= 1'b0;
      rot_eoi_p <= 1'b0;
      spec_eoi_p <= 1'b0;
      set_prio_p <= 1'b0;
      spec_rot_p <= 1'b0;
      cmd_line <= '0;
      poll_clr_p <= 1'b0;
      poll_clr_line <= '0;
      single_seen <= 1'b0;
      level_seen <= 1'b0;
    end else begin
      init_p <= 1'b0;
      mask_wr_p <= 1'b0;
      eoi_p <= 1'b0;
      rot_eoi_p <= 1'b0;
      spec_eoi_p <= 1'b0;
      set_prio_p <= 1'b0;
      spec_rot_p <= 1'b0;
      poll_clr_p <= 1'b0;

      if (rd_en && poll_on && !wr0) begin
        poll_on <= 1'b0;
        poll_clr_p <= pend_vld;
        poll_clr_line <= pend_line;
      end

      if (wr_init) begin
        init_p <= 1'b1;
        step <= ST_BASE;
        want4 <= wdata[0];
        single_seen <= single_seen | wdata[1];
        level_seen <= level_seen | wdata[3];
        imr <= '0;
        vec_base <= '0;
        auto_eoi <= 1'b0;
        rot_auto_eoi <= 1'b0;
        full_nest <= 1'b0;
        spec_mask <= 1'b0;
        rd_isr <= 1'b0;
        poll_on <= 1'b0;
      end

      if (wr_mode) begin
        if (wdata[2]) poll_on <= 1'b1;
        if (wdata[1]) rd_isr <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end

      if (wr_op) begin
        cmd_line <= wdata[LW-1:0];
        case (wdata[7:5])
          3'd0, 3'd4: rot_auto_eoi <= wdata[7];
          3'd1: eoi_p <= 1'b1;
          3'd5: rot_eoi_p <= 1'b1;
          3'd3: spec_eoi_p <= 1'b1;
          3'd6: set_prio_p <= 1'b1;
          3'd7: spec_rot_p <= 1'b1;
          default: ;
        endcase
      end

      if (wr1) begin
        case (step)
          ST_RUN: begin
            imr <= wdata;
            mask_wr_p <= 1'b1;
          end
          ST_BASE: begin
            vec_base <= wdata[DW-1:LW];
            step <= ST_CASC;
          end
          ST_CASC: step <= want4 ? ST_MODE : ST_RUN;
          default: begin
            full_nest <= wdata[4];
            auto_eoi <= wdata[1];
            step <= ST_RUN;
          end
        endcase
      end
    end
  end
endmodule

module irq_prog_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       pend_vld,
  input logic       poll_on,
  input logic [7:0] imr,
  input logic [4:0] vec_base,
  input logic       auto_eoi,
  input logic       rot_auto_eoi,
  input logic       full_nest,
  input logic       spec_mask,
  input logic       init_p,
  input logic       mask_wr_p,
  input logic       eoi_p,
  input logic       rot_eoi_p,
  input logic       spec_eoi_p,
  input logic       set_prio_p,
  input logic       spec_rot_p,
  input logic       single_seen,
  input logic       level_seen
);
  p_one_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_p, mask_wr_p, eoi_p, rot_eoi_p, spec_eoi_p, set_prio_p, spec_rot_p}));

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_p |-> (imr == 8'h00 && vec_base == 5'd0 && !auto_eoi && !rot_auto_eoi
                && !full_nest && !spec_mask));

  p_single_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    single_seen |=> single_seen);

  p_level_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_seen |=> level_seen);

  p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_p |-> (imr == $past(wdata) && $past(wr_en) && $past(addr)));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr_p && !init_p) |-> $stable(imr));

  p_poll_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_on && !(wr_en && !addr)) |=> !poll_on);

  p_poll_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_on && !pend_vld) |-> rdata == 8'h07);
endmodule

bind irq_prog_if irq_prog_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pend_vld(pend_vld), .poll_on(poll_on),
  .imr(imr), .vec_base(vec_base), .auto_eoi(auto_eoi),
  .rot_auto_eoi(rot_auto_eoi), .full_nest(full_nest), .spec_mask(spec_mask),
  .init_p(init_p), .mask_wr_p(mask_wr_p), .eoi_p(eoi_p),
  .rot_eoi_p(rot_eoi_p), .spec_eoi_p(spec_eoi_p), .set_prio_p(set_prio_p),
  .spec_rot_p(spec_rot_p), .single_seen(single_seen), .level_seen(level_seen)
);

// File: tb/irq_prog_if_test.sv
module irq_prog_if_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] req_bits = 8'h5A, svc_bits = 8'h81;
  logic pend_vld = 1'b0;
  logic [2:0] pend_line = 3'd0;
  logic [7:0] rdata, imr;
  logic [4:0] vec_base;
  logic auto_eoi, rot_auto_eoi, full_nest, spec_mask;
  logic init_p, mask_wr_p, eoi_p, rot_eoi_p, spec_eoi_p, set_prio_p, spec_rot_p;
  logic [2:0] cmd_line, poll_clr_line;
  logic poll_clr_p, single_seen, level_seen;

  irq_prog_if uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_bits(req_bits), .svc_bits(svc_bits),
    .pend_vld(pend_vld), .pend_line(pend_line), .imr(imr), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi), .full_nest(full_nest),
    .spec_mask(spec_mask), .init_p(init_p), .mask_wr_p(mask_wr_p),
    .eoi_p(eoi_p), .rot_eoi_p(rot_eoi_p), .spec_eoi_p(spec_eoi_p),
    .set_prio_p(set_prio_p), .spec_rot_p(spec_rot_p), .cmd_line(cmd_line),
    .poll_clr_p(poll_clr_p), .poll_clr_line(poll_clr_line),
    .single_seen(single_seen), .level_seen(level_seen)
  );

  always #4 clk = ~clk;

  localparam int K_RD = 0, K_IMR = 1, K_VEC = 2, K_MODE = 3, K_PUL = 4, K_LINE = 5;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
    int         due;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [7:0] observe(int k);
    case (k)
      K_RD:   return rdata;
      K_IMR:  return imr;
      K_VEC:  return {3'b000, vec_base};
      K_MODE: return {auto_eoi, rot_auto_eoi, full_nest, spec_mask, single_seen, level_seen, 2'b00};
      K_PUL:  return {init_p, mask_wr_p, eoi_p, rot_eoi_p, spec_eoi_p, set_prio_p, spec_rot_p, poll_clr_p};
      default: return {2'b00, cmd_line, poll_clr_line};
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if (observe(it.kind) !== it.exp) begin
        fails++;
        $display("FAIL %s: kind %0d got %02h expected %02h", it.req, it.kind, observe(it.kind), it.exp);
      end
    end
  end

  task automatic expect_now(int kind, logic [7:0] v, string req);
    item_t it;
    it.kind = kind;
    it.exp = v;
    it.req = req;
    it.due = cyc + 1;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    tick();
    addr = a;
    wdata = d;
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] v, string req);
    tick();
    addr = a;
    rd_en = 1'b1;
    expect_now(K_RD, v, req);
    tick();
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    expect_now(K_MODE, 8'h00, "R1");
    expect_now(K_PUL, 8'h00, "R1");
    expect_now(K_VEC, 8'h00, "R1");
    rd(1'b1, 8'h00, "R1");
    rd(1'b0, 8'h5A, "R1");

    // R2 R3 init with fourth word, unsupported bits set
    wr(1'b0, 8'h1B);
    expect_now(K_PUL, 8'h80, "R2");
    expect_now(K_MODE, 8'h0C, "R3");
    tick();
    expect_now(K_PUL, 8'h00, "R2");
    // R4 vector base, no mask write
    wr(1'b1, 8'hA5);
    expect_now(K_VEC, 8'h14, "R4");
    expect_now(K_PUL, 8'h00, "R4");
    wr(1'b1, 8'h04);
    expect_now(K_PUL, 8'h00, "R4");
    expect_now(K_IMR, 8'h00, "R4");
    // R5 fourth word
    wr(1'b1, 8'h12);
    expect_now(K_MODE, 8'hAC, "R5");
    expect_now(K_IMR, 8'h00, "R5");
    // R11 mask load
    wr(1'b1, 8'h3C);
    expect_now(K_PUL, 8'h40, "R11");
    expect_now(K_IMR, 8'h3C, "R11");
    rd(1'b1, 8'h3C, "R9");

    // R8 rotate-on-auto-EOI and no-op
    wr(1'b0, 8'h80);
    expect_now(K_MODE, 8'hEC, "R8");
    expect_now(K_PUL, 8'h00, "R8");
    wr(1'b0, 8'h40);
    expect_now(K_MODE, 8'hEC, "R8");
    expect_now(K_PUL, 8'h00, "R8");
    expect_now(K_IMR, 8'h3C, "R8");
    wr(1'b0, 8'h00);
    expect_now(K_MODE, 8'hAC, "R8");

    // R7 operations
    wr(1'b0, 8'h20);
    expect_now(K_PUL, 8'h20, "R7");
    tick();
    expect_now(K_PUL, 8'h00, "R7");
    wr(1'b0, 8'hA0);
    expect_now(K_PUL, 8'h10, "R7");
    wr(1'b0, 8'h65);
    expect_now(K_PUL, 8'h08, "R7");
    expect_now(K_LINE, 8'h28, "R7");
    wr(1'b0, 8'hC3);
    expect_now(K_PUL, 8'h04, "R7");
    expect_now(K_LINE, 8'h18, "R7");
    wr(1'b0, 8'hE6);
    expect_now(K_PUL, 8'h02, "R7");
    expect_now(K_LINE, 8'h30, "R7");

    // R6 mode commands, R9 read mux
    wr(1'b0, 8'h0B);
    expect_now(K_PUL, 8'h00, "R6");
    rd(1'b0, 8'h81, "R6");
    wr(1'b0, 8'h09);
    rd(1'b0, 8'h81, "R6");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h5A, "R9");
    wr(1'b0, 8'h68);
    expect_now(K_MODE, 8'hBC, "R6");
    wr(1'b0, 8'h28);
    expect_now(K_MODE, 8'hBC, "R6");
    wr(1'b0, 8'h48);
    expect_now(K_MODE, 8'hAC, "R6");

    // R10 poll with a pending line
    pend_vld = 1'b1;
    pend_line = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b1, 8'h05, "R10");
    expect_now(K_PUL, 8'h01, "R10");
    expect_now(K_LINE, 8'h35, "R10");
    rd(1'b1, 8'h3C, "R10");
    // R10 poll with nothing pending
    pend_vld = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h07, "R10");
    expect_now(K_PUL, 8'h00, "R10");
    rd(1'b0, 8'h5A, "R10");

    // R2 re-init clears read-select, R3 flags persist, R4 short sequence
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h10);
    expect_now(K_PUL, 8'h80, "R2");
    expect_now(K_IMR, 8'h00, "R2");
    expect_now(K_MODE, 8'h0C, "R3");
    rd(1'b0, 8'h5A, "R2");
    wr(1'b1, 8'hF8);
    expect_now(K_VEC, 8'h1F, "R4");
    expect_now(K_IMR, 8'h00, "R4");
    wr(1'b1, 8'h00);
    expect_now(K_IMR, 8'h00, "R4");
    wr(1'b1, 8'h55);
    expect_now(K_PUL, 8'h40, "R4");
    expect_now(K_IMR, 8'h55, "R4");
    expect_now(K_MODE, 8'h0C, "R5");

    repeat (3) tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule